// File: doc/BRIEF.md
# Debug Port Protocol Mode Detector

This block sits on the shared clock and mode/data line of a debug port that can speak either a two-wire serial protocol or JTAG. It samples the line on every rising clock edge and decides which protocol owns the port. To do this it tracks how many consecutive high samples it has seen and looks for a 16-bit selection word that follows such a run. The first bit of the word on the wire is its least significant bit.

A run of `RESET_LEN` or more consecutive high samples is a line reset. A line reset arms the detector. The first low sample after an armed run starts a 16-bit word. When the word is complete it is compared against two selection codes: one selects JTAG and one selects the serial-wire protocol. The outputs are a mode flag, a one-cycle line-reset pulse, a one-cycle switch pulse, and a one-cycle TAP reset pulse. The TAP reset pulse tells the TAP controller next to this block to enter Test-Logic-Reset. Each output is registered and changes on the clock edge that samples the bit which caused it.

The controller has three states:
- `ST_HUNT`: waiting for a line reset. Any completed line reset moves it to `ST_ARMED`, whatever the current state.
- `ST_ARMED`: the line reset is complete and the line is still high. A low sample moves it to `ST_COLLECT` and counts as bit 0 of the word.
- `ST_COLLECT`: counting the remaining 15 bits. On the edge that samples bit 15 it returns to `ST_HUNT`, whether or not the word matched.

Top module: `dbg_port_mode_detect`

## Requirements
- R1: While reset (`rst_n` low) is applied, and on leaving it, `jtag_mode_o` is 1 (JTAG selected) and `line_reset_o`, `switch_det_o` and `tap_reset_o` are 0.
- R2: `line_reset_o` goes high for exactly one cycle, after the edge that samples the 50th consecutive high on `line_i`. A run of 49 highs gives no pulse, and a run longer than 50 gives only one pulse.
- R3: A single low sample clears the high-run count, so highs before and after that low are not added together.
- R4: After a line reset, the word 0xE73C sent least-significant bit first sets `jtag_mode_o` to 1. It also raises `switch_det_o` for one cycle, after the edge that samples the 16th bit.
- R5: After a line reset, the word 0xE79E sent least-significant bit first clears `jtag_mode_o` to 0 (serial-wire selected). It also raises `switch_det_o` for one cycle, after the edge that samples the 16th bit.
- R6: A selection word that is not preceded by a completed run of at least 50 highs is ignored: no pulse and no mode change.
- R7: Each word needs its own line reset. A second word sent straight after a first word, whether the first matched or not, is ignored.
- R8: `tap_reset_o` pulses together with `line_reset_o` exactly when `jtag_mode_o` is 1 at that edge. In serial-wire mode it stays low. It fires again for a run that follows a JTAG selection, even when the port was already in JTAG mode.
- R9: `jtag_mode_o` changes only on an edge where `switch_det_o` rises. It does not change on bits 0 to 14 of a word.
- R10: A 16-bit word that equals neither selection code leaves `jtag_mode_o` unchanged and gives no `switch_det_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous power-on or external reset |
| line_i | input | 1 | Shared mode/data line |
| jtag_mode_o | output | 1 | 1 = JTAG active, 0 = serial-wire active |
| line_reset_o | output | 1 | One-cycle pulse when a high run reaches the reset length |
| switch_det_o | output | 1 | One-cycle pulse when a selection word is accepted |
| tap_reset_o | output | 1 | One-cycle pulse telling the TAP to enter Test-Logic-Reset |

## Verification
The bench drives high runs that stop one short of the reset length, runs that overshoot it, and runs broken by a single low. These show the count threshold, saturation and clearing. A design off by one on the threshold would pulse on the 49th or the 51st high. A design that wraps instead of saturating would pulse twice in a long run.

Selection words are sent with and without a preceding line reset, back to back, and with one bit flipped. A detector that keeps its armed state after a word would accept the second of two words sent back to back. A detector that compares on every cycle without a bit count would switch in the middle of a word.

The TAP reset pulse is checked in both modes. Gating it on the wrong mode would either reset the TAP while the serial-wire protocol is active, or miss the reset that follows a JTAG selection.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    // Controller states of the mode detector.
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,   // no completed line reset yet
        ST_ARMED   = 2'd1,   // line reset done, line still high
        ST_COLLECT = 2'd2    // gathering the 16-bit selection word
    } dpm_state_e;

    localparam int unsigned DPM_PAT_W = 16;

endpackage

// File: rtl/dpm_high_run.sv
// Saturating counter of consecutive high samples on the shared line.
module dpm_high_run #(
    parameter int unsigned RESET_LEN = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic hit_o
);
    localparam int unsigned CW = $clog2(RESET_LEN + 1);
    localparam logic [CW-1:0] LIMIT   = CW'(RESET_LEN);
    localparam logic [CW-1:0] PRE_LIM = CW'(RESET_LEN - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!line_i) begin
            run_cnt <= '0;
        end else if (run_cnt != LIMIT) begin
            run_cnt <= run_cnt + CW'(1);
        end
    end

    // True while the current sample completes the run; true once per run
    // because the counter holds at LIMIT afterwards.
    assign hit_o = line_i && (run_cnt == PRE_LIM);

endmodule

// File: rtl/dpm_pattern_shift.sv
// Shift register that gathers the selection word LSB first and compares the
// word it would hold after the current sample against both selection codes.
module dpm_pattern_shift #(
    parameter int unsigned     PAT_W    = 16,
    parameter logic [PAT_W-1:0] CODE_JTAG = 16'hE73C,
    parameter logic [PAT_W-1:0] CODE_SW   = 16'hE79E
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic to_jtag_o,
    output logic to_sw_o
);
    logic [PAT_W-1:0] word_q;
    logic [PAT_W-1:0] word_nx;

    // New bits enter at the MSB end so the first bit on the wire ends at bit 0.
    for (genvar g = 0; g < int'(PAT_W); g++) begin : g_bit
        if (g == int'(PAT_W) - 1) begin : g_top
            assign word_nx[g] = line_i;
        end else begin : g_mid
            assign word_nx[g] = word_q[g+1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_nx;
        end
    end

    assign to_jtag_o = (word_nx == CODE_JTAG);
    assign to_sw_o   = (word_nx == CODE_SW);

endmodule

// File: rtl/dpm_mode_fsm.sv
// Controller: arms on a line reset, counts word bits, holds the mode flag.
module dpm_mode_fsm
    import dpm_pkg::*;
#(
    parameter int unsigned PAT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic run_hit_i,
    input  logic to_jtag_i,
    input  logic to_sw_i,
    output logic jtag_mode_o,
    output logic line_reset_o,
    output logic switch_det_o,
    output logic tap_reset_o
);
    localparam int unsigned BW = $clog2(PAT_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(PAT_W - 1);

    dpm_state_e    state_q, state_d;
    logic [BW-1:0] bit_q, bit_d;
    logic          word_done;

    assign word_done = (state_q == ST_COLLECT) && (bit_q == LAST_BIT);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        if (run_hit_i) begin
            state_d = ST_ARMED;
            bit_d   = '0;
        end else begin
            unique case (state_q)
                ST_HUNT: begin
                    state_d = ST_HUNT;
                end
                ST_ARMED: begin
                    if (!line_i) begin
                        state_d = ST_COLLECT;
                        bit_d   = BW'(1);
                    end
                end
                ST_COLLECT: begin
                    if (bit_q == LAST_BIT) begin
                        state_d = ST_HUNT;
                        bit_d   = '0;
                    end else begin
                        bit_d = bit_q + BW'(1);
                    end
                end
                default: begin
                    state_d = ST_HUNT;
                    bit_d   = '0;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
        end
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            jtag_mode_o  <= 1'b1;
            line_reset_o <= 1'b0;
            switch_det_o <= 1'b0;
            tap_reset_o  <= 1'b0;
        end else begin
            line_reset_o <= run_hit_i;
            tap_reset_o  <= run_hit_i && jtag_mode_o;
            switch_det_o <= word_done && (to_jtag_i || to_sw_i);
            if (word_done && to_jtag_i) begin
                jtag_mode_o <= 1'b1;
            end else if (word_done && to_sw_i) begin
                jtag_mode_o <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dbg_port_mode_detect.sv
// Top level: debug port protocol mode detector.
module dbg_port_mode_detect #(
    parameter int unsigned      RESET_LEN = 50,
    parameter logic [15:0]      CODE_JTAG = 16'hE73C,
    parameter logic [15:0]      CODE_SW   = 16'hE79E
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic jtag_mode_o,
    output logic line_reset_o,
    output logic switch_det_o,
    output logic tap_reset_o
);
    localparam int unsigned PAT_W = dpm_pkg::DPM_PAT_W;

    logic run_hit;
    logic to_jtag;
    logic to_sw;

    dpm_high_run #(
        .RESET_LEN (RESET_LEN)
    ) u_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i),
        .hit_o  (run_hit)
    );

    dpm_pattern_shift #(
        .PAT_W     (PAT_W),
        .CODE_JTAG (CODE_JTAG),
        .CODE_SW   (CODE_SW)
    ) u_pat (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (line_i),
        .to_jtag_o (to_jtag),
        .to_sw_o   (to_sw)
    );

    dpm_mode_fsm #(
        .PAT_W (PAT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (line_i),
        .run_hit_i    (run_hit),
        .to_jtag_i    (to_jtag),
        .to_sw_i      (to_sw),
        .jtag_mode_o  (jtag_mode_o),
        .line_reset_o (line_reset_o),
        .switch_det_o (switch_det_o),
        .tap_reset_o  (tap_reset_o)
    );

endmodule

// File: rtl/dbg_port_mode_detect_chk.sv
// Property checker for the mode detector, attached through bind.
module dbg_port_mode_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic line_i,
    input logic jtag_mode_o,
    input logic line_reset_o,
    input logic switch_det_o,
    input logic tap_reset_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (jtag_mode_o && !line_reset_o && !switch_det_o && !tap_reset_o));

    // R2
    lr_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_reset_o |-> $past(line_i));

    // R2
    lr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_reset_o |=> !line_reset_o);

    // R8
    tap_needs_lr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tap_reset_o |-> (line_reset_o && jtag_mode_o));

    // R8
    tap_in_jtag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_reset_o && jtag_mode_o) |-> tap_reset_o);

    // R9
    mode_on_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(jtag_mode_o) |-> switch_det_o);

    // R4
    sw_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        switch_det_o |=> !switch_det_o);

    // R7
    sw_not_with_lr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        switch_det_o |-> !line_reset_o);

endmodule

bind dbg_port_mode_detect dbg_port_mode_detect_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_i       (line_i),
    .jtag_mode_o  (jtag_mode_o),
    .line_reset_o (line_reset_o),
    .switch_det_o (switch_det_o),
    .tap_reset_o  (tap_reset_o)
);

// File: tb/dbg_port_mode_detect_tb.sv
`timescale 1ns/1ps
module dbg_port_mode_detect_tb;

    localparam logic [15:0] W_JTAG = 16'hE73C;
    localparam logic [15:0] W_SW   = 16'hE79E;
    localparam logic [15:0] W_BAD  = 16'hE63C;

    logic clk = 1'b0;
    logic rst_n;
    logic line_i;
    logic jtag_mode_o, line_reset_o, switch_det_o, tap_reset_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    dbg_port_mode_detect u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (line_i),
        .jtag_mode_o  (jtag_mode_o),
        .line_reset_o (line_reset_o),
        .switch_det_o (switch_det_o),
        .tap_reset_o  (tap_reset_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    // Drive one sample; return after the edge that samples it.
    task automatic send_bit(input logic b);
        @(negedge clk);
        line_i = b;
        @(posedge clk);
        #1;
    endtask

    task automatic run_high(input int n, output int first_lr, output int n_lr,
                            output int n_tr);
        first_lr = -1; n_lr = 0; n_tr = 0;
        for (int i = 1; i <= n; i++) begin
            send_bit(1'b1);
            if (line_reset_o) begin
                n_lr++;
                if (first_lr < 0) first_lr = i;
            end
            if (tap_reset_o) n_tr++;
        end
    endtask

    task automatic send_word(input logic [15:0] w, output int sw_at, output int sw_cnt,
                             output int early_flips);
        logic m0;
        sw_at = -1; sw_cnt = 0; early_flips = 0;
        m0 = jtag_mode_o;
        for (int i = 0; i < 16; i++) begin
            send_bit(w[i]);
            if (switch_det_o) begin
                sw_cnt++;
                sw_at = i;
            end
            if (i < 15 && jtag_mode_o != m0) early_flips++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        line_i = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        check_eq("R1 mode in reset", int'(jtag_mode_o), 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_eq("R1 mode after reset", int'(jtag_mode_o), 1);
        check_eq("R1 pulses after reset",
                 int'(line_reset_o) + int'(switch_det_o) + int'(tap_reset_o), 0);
    endtask

    task automatic t_run_length();
        int f, n, t;
        send_bit(1'b0);
        run_high(49, f, n, t);
        check_eq("R2 no pulse at 49", n, 0);
        send_bit(1'b0);
        run_high(50, f, n, t);
        check_eq("R2 pulse index", f, 50);
        check_eq("R2 pulse count", n, 1);
        check_eq("R8 tap pulse in JTAG", t, 1);
        run_high(20, f, n, t);
        check_eq("R2 saturation, no repeat", n, 0);
    endtask

    task automatic t_low_clears();
        int f, n, t;
        send_bit(1'b0);
        run_high(30, f, n, t);
        send_bit(1'b0);
        run_high(49, f, n, t);
        check_eq("R3 low clears count", n, 0);
        run_high(1, f, n, t);
        check_eq("R3 pulse at 50 after low", n, 1);
    endtask

    task automatic t_to_sw();
        int a, c, e, f, n, t;
        send_word(W_SW, a, c, e);
        check_eq("R5 switch pulse bit", a, 15);
        check_eq("R5 switch pulse count", c, 1);
        check_eq("R5 mode serial-wire", int'(jtag_mode_o), 0);
        check_eq("R9 no early mode change", e, 0);
        send_bit(1'b0);
        run_high(50, f, n, t);
        check_eq("R8 line reset in serial-wire", n, 1);
        check_eq("R8 no tap pulse in serial-wire", t, 0);
    endtask

    task automatic t_to_jtag();
        int a, c, e, f, n, t;
        send_word(W_JTAG, a, c, e);
        check_eq("R4 switch pulse bit", a, 15);
        check_eq("R4 mode JTAG", int'(jtag_mode_o), 1);
        check_eq("R9 no early mode change", e, 0);
        send_bit(1'b0);
        run_high(50, f, n, t);
        check_eq("R8 tap pulse after JTAG select", t, 1);
    endtask

    task automatic t_need_reset();
        int a, c, e, f, n, t;
        send_word(W_SW, a, c, e);
        check_eq("R5 mode serial-wire", int'(jtag_mode_o), 0);
        send_word(W_JTAG, a, c, e);
        check_eq("R7 back-to-back word pulse", c, 0);
        check_eq("R7 back-to-back word mode", int'(jtag_mode_o), 0);
        send_bit(1'b0);
        run_high(49, f, n, t);
        send_word(W_JTAG, a, c, e);
        check_eq("R6 short run word pulse", c, 0);
        check_eq("R6 short run word mode", int'(jtag_mode_o), 0);
    endtask

    task automatic t_mismatch();
        int a, c, e, f, n, t;
        send_bit(1'b0);
        run_high(50, f, n, t);
        send_word(W_BAD, a, c, e);
        check_eq("R10 mismatch pulse", c, 0);
        check_eq("R10 mismatch mode", int'(jtag_mode_o), 0);
        send_bit(1'b0);
        run_high(55, f, n, t);
        send_word(W_JTAG, a, c, e);
        check_eq("R4 accept after long run", c, 1);
        check_eq("R4 mode JTAG after long run", int'(jtag_mode_o), 1);
    endtask

    initial begin
        t_reset();
        t_run_length();
        t_low_clears();
        t_to_sw();
        t_to_jtag();
        t_need_reset();
        t_mismatch();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule